// File: doc/BRIEF.md
# Relocatable Priority Memory Address Decoder

This block turns a 16-bit processor address into one select line per memory resource: an on-chip register block, an on-chip RAM, an on-chip ROM and the external bus. The RAM and the register block can each be moved to any 4K boundary. A 4-bit position input sets the top hex digit of each block's base. The ROM sits at the top of the address space and can be switched off for variants that have no ROM.

The windows may overlap. When they do, a fixed priority settles the owner: the register block wins first, then the RAM, then the ROM. The external bus is selected only when no internal window claims the address. Read data is taken from the selected source, so external data is ignored whenever an internal device answers. Write strobes are routed only to writable targets, so a write that decodes to the ROM reaches no device. The decode is purely combinational, from the address, the write strobe, the two position inputs and the ROM enable.

Top module: `mem_addr_decoder`

## Requirements
- R1: The RAM window covers addresses ram_pos*4096 up to ram_pos*4096+511. In this range the RAM is selected unless the register block claims the address.
- R2: The register window covers addresses reg_pos*4096 up to reg_pos*4096+63. In this range the register block is always selected.
- R3: When rom_enable is 1, addresses 0xD000 to 0xFFFF claim the ROM. When rom_enable is 0, the ROM is never selected.
- R4: Where windows overlap, priority runs register block, then RAM, then ROM.
- R5: Exactly one of reg_sel, ram_sel, rom_sel and ext_sel is 1 for every input combination.
- R6: ext_sel is 1 exactly when no internal window claims the address. This includes the ROM range while rom_enable is 0.
- R7: cpu_rdata equals the read data of the selected source. ext_rdata has no effect while any internal device is selected.
- R8: reg_we, ram_we and ext_we each equal cpu_wr ANDed with their own select. A write that decodes to the ROM raises none of them.
- R9: With both positions at 0xD and the ROM enabled, the ownership is as follows. The register block answers 0xD000 to 0xD03F. The RAM answers 0xD040 to 0xD1FF. The ROM answers 0xD200 to 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cpu_addr | input | 16 | Processor address |
| cpu_wr | input | 1 | Write strobe, 1 = write cycle |
| ram_pos | input | 4 | Top hex digit of the RAM base |
| reg_pos | input | 4 | Top hex digit of the register block base |
| rom_enable | input | 1 | 1 = ROM window active |
| reg_rdata | input | 8 | Read data from the register block |
| ram_rdata | input | 8 | Read data from the RAM |
| rom_rdata | input | 8 | Read data from the ROM |
| ext_rdata | input | 8 | Read data from the external bus |
| reg_sel | output | 1 | Register block selected |
| ram_sel | output | 1 | RAM selected |
| rom_sel | output | 1 | ROM selected |
| ext_sel | output | 1 | External bus selected |
| reg_we | output | 1 | Write enable to the register block |
| ram_we | output | 1 | Write enable to the RAM |
| ext_we | output | 1 | Write enable to the external bus |
| cpu_rdata | output | 8 | Read data returned to the processor |

## Verification
The assertions are evaluated whenever an input changes. They check the following: the selects are one-hot, a raw register hit always wins, and a RAM hit beats the ROM. They also check that the external bus is chosen only when nothing internal hits, that ROM-decoded writes raise no enable, and that internal read data bypasses the external input. These checks compare the select outputs with the raw window hits, so they cannot detect a wrong window boundary or a misplaced base. Only the bench's full address sweeps can show those errors. The sweeps cover several position pairs, including coincident and adjacent windows, with the ROM on and off, and compare every address against bases computed arithmetically. The bench also spot-checks the exact ownership split when all three windows share 0xD000.

// File: rtl/mad_pkg.sv
package mad_pkg;
  localparam int N_SRC = 4;
  typedef enum logic [1:0] {
    SRC_REG = 2'd0,
    SRC_RAM = 2'd1,
    SRC_ROM = 2'd2,
    SRC_EXT = 2'd3
  } src_e;
endpackage

// File: rtl/mad_window.sv
module mad_window #(
  parameter int ADDR_W = 16,
  parameter int POS_W  = 4,
  parameter int SPAN   = 512
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [POS_W-1:0]  pos,
  output logic              hit
);
  localparam int OFF_W = ADDR_W - POS_W;

  function automatic logic in_span(input logic [OFF_W-1:0] off);
    return off < OFF_W'(SPAN);
  endfunction

  function automatic logic page_match(input logic [ADDR_W-1:0] a,
                                      input logic [POS_W-1:0] p);
    return a[ADDR_W-1 -: POS_W] == p;
  endfunction

  assign hit = page_match(addr, pos) && in_span(addr[OFF_W-1:0]);
endmodule

// File: rtl/mad_rom_window.sv
module mad_rom_window #(
  parameter int              ADDR_W   = 16,
  parameter logic [ADDR_W-1:0] ROM_BASE = 16'hD000
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              enable,
  output logic              hit
);
  function automatic logic above_base(input logic [ADDR_W-1:0] a);
    return a >= ROM_BASE;
  endfunction

  assign hit = enable && above_base(addr);
endmodule

// File: rtl/mad_prio.sv
module mad_prio #(
  parameter int N = 4
) (
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  always_comb begin
    logic taken;
    taken = 1'b0;
    gnt   = '0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !taken) begin
        gnt[i] = 1'b1;
        taken  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/mad_rdata_mux.sv
module mad_rdata_mux #(
  parameter int N      = 4,
  parameter int DATA_W = 8
) (
  input  logic [N-1:0]             gnt,
  input  logic [N-1:0][DATA_W-1:0] src_data,
  output logic [DATA_W-1:0]        rdata
);
  always_comb begin
    rdata = '0;
    for (int i = 0; i < N; i++) begin
      rdata = rdata | (src_data[i] & {DATA_W{gnt[i]}});
    end
  end
endmodule

// File: rtl/mem_addr_decoder.sv
module mem_addr_decoder
  import mad_pkg::*;
#(
  parameter int              ADDR_W    = 16,
  parameter int              DATA_W    = 8,
  parameter int              POS_W     = 4,
  parameter int              RAM_BYTES = 512,
  parameter int              REG_BYTES = 64,
  parameter logic [15:0]     ROM_BASE  = 16'hD000
) (
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic [POS_W-1:0]  ram_pos,
  input  logic [POS_W-1:0]  reg_pos,
  input  logic              rom_enable,
  input  logic [DATA_W-1:0] reg_rdata,
  input  logic [DATA_W-1:0] ram_rdata,
  input  logic [DATA_W-1:0] rom_rdata,
  input  logic [DATA_W-1:0] ext_rdata,
  output logic              reg_sel,
  output logic              ram_sel,
  output logic              rom_sel,
  output logic              ext_sel,
  output logic              reg_we,
  output logic              ram_we,
  output logic              ext_we,
  output logic [DATA_W-1:0] cpu_rdata
);
  // Raw window hits, before priority; exported for the checker.
  logic reg_hit;
  logic ram_hit;
  logic rom_hit;
  logic [N_SRC-1:0] req;
  logic [N_SRC-1:0] gnt;
  logic [N_SRC-1:0][DATA_W-1:0] src_data;

  mad_window #(.ADDR_W(ADDR_W), .POS_W(POS_W), .SPAN(REG_BYTES)) u_reg_win (
    .addr(cpu_addr), .pos(reg_pos), .hit(reg_hit)
  );

  mad_window #(.ADDR_W(ADDR_W), .POS_W(POS_W), .SPAN(RAM_BYTES)) u_ram_win (
    .addr(cpu_addr), .pos(ram_pos), .hit(ram_hit)
  );

  mad_rom_window #(.ADDR_W(ADDR_W), .ROM_BASE(ADDR_W'(ROM_BASE))) u_rom_win (
    .addr(cpu_addr), .enable(rom_enable), .hit(rom_hit)
  );

  // Index order is the priority order; the external bus always requests.
  always_comb begin
    req          = '0;
    req[SRC_REG] = reg_hit;
    req[SRC_RAM] = ram_hit;
    req[SRC_ROM] = rom_hit;
    req[SRC_EXT] = 1'b1;
  end

  mad_prio #(.N(N_SRC)) u_prio (.req(req), .gnt(gnt));

  assign reg_sel = gnt[SRC_REG];
  assign ram_sel = gnt[SRC_RAM];
  assign rom_sel = gnt[SRC_ROM];
  assign ext_sel = gnt[SRC_EXT];

  // The ROM has no write enable at all: a write decoded there goes nowhere.
  assign reg_we = cpu_wr & reg_sel;
  assign ram_we = cpu_wr & ram_sel;
  assign ext_we = cpu_wr & ext_sel;

  always_comb begin
    src_data          = '0;
    src_data[SRC_REG] = reg_rdata;
    src_data[SRC_RAM] = ram_rdata;
    src_data[SRC_ROM] = rom_rdata;
    src_data[SRC_EXT] = ext_rdata;
  end

  mad_rdata_mux #(.N(N_SRC), .DATA_W(DATA_W)) u_mux (
    .gnt(gnt), .src_data(src_data), .rdata(cpu_rdata)
  );
endmodule

// File: rtl/mad_decoder_chk.sv
module mad_decoder_chk #(
  parameter int DATA_W = 8
) (
  input logic              cpu_wr,
  input logic              reg_hit,
  input logic              ram_hit,
  input logic              rom_hit,
  input logic              reg_sel,
  input logic              ram_sel,
  input logic              rom_sel,
  input logic              ext_sel,
  input logic              reg_we,
  input logic              ram_we,
  input logic              ext_we,
  input logic [DATA_W-1:0] reg_rdata,
  input logic [DATA_W-1:0] ram_rdata,
  input logic [DATA_W-1:0] rom_rdata,
  input logic [DATA_W-1:0] ext_rdata,
  input logic [DATA_W-1:0] cpu_rdata
);
  always_comb begin
    a_r5_one_select: assert ($countones({reg_sel, ram_sel, rom_sel, ext_sel}) == 1);
    a_r2_reg_wins: assert (!reg_hit || reg_sel);
    a_r4_ram_over_rom: assert (!(ram_hit && !reg_hit) || ram_sel);
    a_r6_ext_unclaimed: assert (ext_sel == !(reg_hit || ram_hit || rom_hit));
    a_r8_rom_write_dropped: assert (!(rom_sel && cpu_wr) || !(reg_we || ram_we || ext_we));
    a_r7_internal_data: assert ((!reg_sel || cpu_rdata == reg_rdata) &&
                                (!ram_sel || cpu_rdata == ram_rdata) &&
                                (!rom_sel || cpu_rdata == rom_rdata));
    a_r7_ext_data: assert (!ext_sel || cpu_rdata == ext_rdata);
  end
endmodule

bind mem_addr_decoder mad_decoder_chk #(.DATA_W(DATA_W)) u_chk (
  .cpu_wr(cpu_wr), .reg_hit(reg_hit), .ram_hit(ram_hit), .rom_hit(rom_hit),
  .reg_sel(reg_sel), .ram_sel(ram_sel), .rom_sel(rom_sel), .ext_sel(ext_sel),
  .reg_we(reg_we), .ram_we(ram_we), .ext_we(ext_we),
  .reg_rdata(reg_rdata), .ram_rdata(ram_rdata), .rom_rdata(rom_rdata),
  .ext_rdata(ext_rdata), .cpu_rdata(cpu_rdata)
);

// File: tb/mem_addr_decoder_tb.sv
module mem_addr_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic        cpu_wr = 1'b0;
  logic [3:0]  ram_pos = 4'h0;
  logic [3:0]  reg_pos = 4'h1;
  logic        rom_enable = 1'b1;
  logic [7:0]  reg_rdata = 8'hA1;
  logic [7:0]  ram_rdata = 8'hB2;
  logic [7:0]  rom_rdata = 8'hC3;
  logic [7:0]  ext_rdata = 8'hE4;
  logic reg_sel, ram_sel, rom_sel, ext_sel, reg_we, ram_we, ext_we;
  logic [7:0] cpu_rdata;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mem_addr_decoder u_dut (
    .cpu_addr(cpu_addr), .cpu_wr(cpu_wr), .ram_pos(ram_pos), .reg_pos(reg_pos),
    .rom_enable(rom_enable), .reg_rdata(reg_rdata), .ram_rdata(ram_rdata),
    .rom_rdata(rom_rdata), .ext_rdata(ext_rdata), .reg_sel(reg_sel),
    .ram_sel(ram_sel), .rom_sel(rom_sel), .ext_sel(ext_sel), .reg_we(reg_we),
    .ram_we(ram_we), .ext_we(ext_we), .cpu_rdata(cpu_rdata)
  );

  task automatic report;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      $display("FAIL watchdog: actual timeout, expected completion");
      errors++;
      checks++;
      report();
    end
  end

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s addr=%h ram_pos=%h reg_pos=%h rom_en=%0d actual=%h expected=%h",
               tag, cpu_addr, ram_pos, reg_pos, rom_enable, act, exp);
    end
  endtask

  // Expected owner: 3=reg,2=ram,1=rom,0=ext, from arithmetic base/limit.
  task automatic check_here;
    int a, rb, mb, nhit;
    bit h_reg, h_ram, h_rom;
    logic [3:0] exp_sel;
    logic [7:0] exp_d;
    string tag;
    a  = int'(cpu_addr);
    rb = int'(reg_pos) * 4096;
    mb = int'(ram_pos) * 4096;
    h_reg = (a >= rb) && (a < rb + 64);
    h_ram = (a >= mb) && (a < mb + 512);
    h_rom = rom_enable && (a >= 53248);
    nhit = int'(h_reg) + int'(h_ram) + int'(h_rom);
    if (h_reg)      begin exp_sel = 4'b1000; exp_d = 8'hA1; tag = "R2"; end
    else if (h_ram) begin exp_sel = 4'b0100; exp_d = 8'hB2; tag = "R1"; end
    else if (h_rom) begin exp_sel = 4'b0010; exp_d = 8'hC3; tag = "R3"; end
    else            begin exp_sel = 4'b0001; exp_d = 8'hE4; tag = "R6"; end
    if (nhit > 1) tag = "R4";
    expect_eq(tag, int'({reg_sel, ram_sel, rom_sel, ext_sel}), int'(exp_sel));
    expect_eq("R5", $countones({reg_sel, ram_sel, rom_sel, ext_sel}), 1);
    expect_eq("R7", int'(cpu_rdata), int'(exp_d));
    expect_eq("R8", int'({reg_we, ram_we, ext_we}),
              int'({cpu_wr & exp_sel[3], cpu_wr & exp_sel[2], cpu_wr & exp_sel[0]}));
  endtask

  task automatic sweep(input logic [3:0] rp, input logic [3:0] gp, input bit re);
    ram_pos = rp;
    reg_pos = gp;
    rom_enable = re;
    for (int a = 0; a < 65536; a++) begin
      cpu_addr = a[15:0];
      cpu_wr = a[0] ^ a[9];
      #2;
      check_here();
    end
  endtask

  task automatic spot(input logic [15:0] a, input logic [3:0] exp_sel);
    cpu_addr = a;
    cpu_wr = 1'b0;
    #2;
    expect_eq("R9", int'({reg_sel, ram_sel, rom_sel, ext_sel}), int'(exp_sel));
  endtask

  initial begin
    #25;
    rst_n = 1'b1;
    // Default placement after reset: RAM at 0x0000, registers at 0x1000.
    sweep(4'h0, 4'h1, 1'b1);
    // R9: all three windows stacked at 0xD000.
    ram_pos = 4'hD; reg_pos = 4'hD; rom_enable = 1'b1;
    spot(16'hD000, 4'b1000);
    spot(16'hD03F, 4'b1000);
    spot(16'hD040, 4'b0100);
    spot(16'hD1FF, 4'b0100);
    spot(16'hD200, 4'b0010);
    spot(16'hFFFF, 4'b0010);
    sweep(4'hD, 4'hD, 1'b1);
    sweep(4'h3, 4'h3, 1'b1);
    sweep(4'hF, 4'hE, 1'b0);
    sweep(4'hD, 4'hD, 1'b0);
    // R7: external data changed while an internal device owns the address.
    ram_pos = 4'h0; reg_pos = 4'h1; rom_enable = 1'b1;
    cpu_addr = 16'h0010; ext_rdata = 8'h5A; #2;
    expect_eq("R7", int'(cpu_rdata), 8'hB2);
    cpu_addr = 16'hE000; #2;
    expect_eq("R7", int'(cpu_rdata), 8'hC3);
    cpu_addr = 16'h8000; #2;
    expect_eq("R7", int'(cpu_rdata), 8'h5A);
    // R3/R8: ROM write reaches nothing.
    cpu_addr = 16'hF000; cpu_wr = 1'b1; #2;
    expect_eq("R8", int'({reg_we, ram_we, ext_we}), 0);
    expect_eq("R3", int'(rom_sel), 1);
    done = 1'b1;
    report();
  end
endmodule